// File: doc/BRIEF.md
# Two-Wire Serial Register Access Slave

This block lets an external two-wire bus master read and write a bank of 8-bit control registers. It synchronises SCL and SDA into the system clock domain and detects clock edges and start and stop conditions. It then runs a byte-level protocol engine and drives SDA low through an open-drain enable. That enable is used both to acknowledge a byte and to send read data.

A write transaction carries the device address with the direction bit clear, then one byte that loads an internal index, then any number of data bytes. Each data byte is written to the register the index points to, and the index then steps by one. A read is indirect. The master first loads the index with a write that has no data bytes. It then issues a repeated start with the direction bit set, and the slave returns bytes from the index onward. The register bank is outside this block. It sees an address, write data and a one-cycle write strobe, and it returns read data and a flag that says whether the address names a defined register. The slave withholds its acknowledge from any access to an address that is not defined.

Top module: `i2c_regif_slave`

## Requirements
- R1: During and after synchronous reset, `sda_oe` and `reg_we` are low.
- R2: The first byte after a start holds a 7-bit device address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The slave acknowledges only when the address equals `DEV_ADDR`. On a mismatch, including a mismatch after a repeated start, it keeps `sda_oe` low until the next start.
- R3: An acknowledge is SDA held low by the slave during the ninth SCL clock of a byte. A not-acknowledge leaves SDA high.
- R4: In a write, the byte after the device address loads the index. Each following data byte is received MSB first and produces exactly one `reg_we` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the index.
- R5: After each data byte that is written or read, the index increments by one, so a burst touches consecutive registers.
- R6: A register-address byte for which `reg_addr_ok` is low is not acknowledged and leaves the index unchanged. A data byte whose index is undefined is not acknowledged and produces no `reg_we`.
- R7: A read with a matching address returns the register at the index, MSB first. If the index is undefined, the read address byte is not acknowledged.
- R8: A master acknowledge after a read byte makes the slave send the next register. A master not-acknowledge makes the slave release SDA and ignore the bus until the next start.
- R9: A stop at any point returns the engine to idle. A start at any point, including in the middle of a byte, restarts device-address reception.
- R10: The slave changes `sda_oe` only while SCL is low. It raises the enable only in the cycle after it detects a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| reg_addr | output | 8 | Register address presented to the bank |
| reg_wdata | output | 8 | Write data to the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank at `reg_addr` |
| reg_addr_ok | input | 1 | High when `reg_addr` names a defined register |

## Verification
A table of single-byte write-then-read pairs covers the low, high and middle registers. Its data values include all zeros, all ones and alternating bits, so a lost bit, a reversed bit order or a stuck line would show. Bursts in both directions show whether the index steps once per byte. A burst that runs off the last defined register shows that the acknowledge decision follows the live index and not the starting address. Wrong device addresses, including one sent after a repeated start, and aborts in the middle of a byte by stop or by start show that protocol state is dropped and SDA stays released.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    // Rising SCL edges counted within one byte frame.
    localparam logic [CNT_W-1:0] CNT_DATA_DONE = 4'd8;
    localparam logic [CNT_W-1:0] CNT_ACK_DONE  = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_REGADDR,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
        logic scl;
    } bus_evt_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                       input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
    import i2c_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_p;
    logic                   sda_p;
    logic                   scl_now;
    logic                   sda_now;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_now = scl_sh[SYNC_STAGES-1];
    assign sda_now = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_now;
            sda_p <= sda_now;
        end
    end

    always_comb begin
        evt.scl      = scl_now;
        evt.sda      = sda_now;
        evt.scl_rise = scl_now & ~scl_p;
        evt.scl_fall = ~scl_now & scl_p;
        evt.start    = scl_now & scl_p & sda_p & ~sda_now;
        evt.stop     = scl_now & scl_p & ~sda_p & sda_now;
    end

endmodule

// File: rtl/i2c_regif_fsm.sv
module i2c_regif_fsm
    import i2c_regif_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4A
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic              reg_addr_ok,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we
);

    slv_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] index;
    logic              rd_dir;
    logic              m_nack;
    logic [2:0]        tx_sel;

    // The bank is asked about the incoming byte while it is being judged as an index.
    assign reg_addr  = (state == ST_REGADDR) ? rx_sh : index;
    assign reg_wdata = rx_sh;
    assign tx_sel    = 3'(BYTE_W - 1) - cnt[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            index  <= '0;
            rd_dir <= 1'b0;
            m_nack <= 1'b0;
            sda_oe <= 1'b0;
            reg_we <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (evt.start) begin
                state  <= ST_DEVADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.scl_rise) begin
                if (state != ST_IDLE && state != ST_IGNORE) begin
                    cnt <= cnt + 4'd1;
                    if (state == ST_RDATA) begin
                        if (cnt == CNT_DATA_DONE) m_nack <= evt.sda;
                    end else if (cnt < CNT_DATA_DONE) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], evt.sda};
                    end
                end
            end else if (evt.scl_fall) begin
                if (cnt == CNT_DATA_DONE) begin
                    // Start of the ninth clock: decide on the acknowledge.
                    case (state)
                        ST_DEVADDR: begin
                            if (dev_match(rx_sh, DEV_ADDR) && (!rx_sh[0] || reg_addr_ok)) begin
                                sda_oe <= 1'b1;
                                rd_dir <= rx_sh[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_REGADDR: begin
                            if (reg_addr_ok) begin
                                sda_oe <= 1'b1;
                                index  <= rx_sh;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_WDATA: begin
                            if (reg_addr_ok) begin
                                sda_oe <= 1'b1;
                                reg_we <= 1'b1;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_RDATA: begin
                            sda_oe <= 1'b0;
                            index  <= index + 8'd1;
                        end
                        default: ;
                    endcase
                end else if (cnt == CNT_ACK_DONE) begin
                    // End of the ninth clock: release and move on.
                    cnt    <= '0;
                    sda_oe <= 1'b0;
                    case (state)
                        ST_DEVADDR: begin
                            if (rd_dir) begin
                                state  <= ST_RDATA;
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                state <= ST_REGADDR;
                            end
                        end
                        ST_REGADDR: state <= ST_WDATA;
                        ST_WDATA:   index <= index + 8'd1;
                        ST_RDATA: begin
                            if (m_nack) begin
                                state <= ST_IGNORE;
                            end else begin
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end
                        end
                        default: ;
                    endcase
                end else if (state == ST_RDATA && cnt != '0) begin
                    sda_oe <= ~tx_sh[tx_sel];
                end
            end
        end
    end

    // R1: reset leaves the bus released and no write pending
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && !reg_we));

    // R10: the pull-down is only switched on after a falling SCL edge
    assert_oe_on_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(evt.scl_fall));

    // R4: a write strobe lasts a single cycle
    assert_we_single_R4: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6: no strobe toward an undefined register
    assert_we_defined_R6: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> reg_addr_ok);

    // R9: stop drops to idle and releases SDA
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));

    // R9: start always restarts device-address reception
    assert_start_addr_R9: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_DEVADDR && cnt == '0));

    // R2: an unaddressed slave never pulls SDA
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

endmodule

// File: rtl/i2c_regif_slave.sv
module i2c_regif_slave
    import i2c_regif_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h4A,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata,
    input  logic       reg_addr_ok
);

    bus_evt_t evt;

    i2c_line_cond #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .evt  (evt)
    );

    i2c_regif_fsm #(
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .reg_rdata  (reg_rdata),
        .reg_addr_ok(reg_addr_ok),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we)
    );

endmodule

// File: tb/tb_i2c_regif_slave.sv
module tb_i2c_regif_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam logic [7:0] DEV_W = 8'h94;
    localparam logic [7:0] DEV_R = 8'h95;
    localparam logic [7:0] BAD_W = 8'h96;
    localparam logic [7:0] BAD_R = 8'h97;
    localparam int NVEC = 6;
    // {register, data}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00A5, 16'h1F3C, 16'h0700, 16'h10FF, 16'h0581, 16'h1E5A
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    logic       reg_addr_ok;
    logic [7:0] bank [32];
    int         checks = 0;
    int         fails = 0;
    int         we_cnt = 0;
    int         oe_seen = 0;
    int         oe_hi_changes = 0;
    logic       oe_prev = 1'b0;
    logic       scl_prev = 1'b1;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_addr_ok = reg_addr < 8'd32;
    assign reg_rdata   = reg_addr_ok ? bank[reg_addr[4:0]] : 8'h00;

    i2c_regif_slave dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_rdata  (reg_rdata),
        .reg_addr_ok(reg_addr_ok)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) bank[i] <= 8'h00;
        end else begin
            if (reg_we) begin
                we_cnt <= we_cnt + 1;
                if (reg_addr_ok) bank[reg_addr[4:0]] <= reg_wdata;
            end
            if (sda_oe) oe_seen <= oe_seen + 1;
            if (scl_m && scl_prev && sda_oe != oe_prev) oe_hi_changes <= oe_hi_changes + 1;
        end
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        ack = ~sda_line; tick(Q/2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q/2);
            b[i] = sda_line; tick(Q/2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic set_index(input logic [7:0] r, output logic a1, output logic a2);
        bus_start;
        send_byte(DEV_W, a1);
        send_byte(r, a2);
    endtask

    task automatic read_one(input logic [7:0] r, output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        set_index(r, a1, a2);
        bus_start;
        send_byte(DEV_R, a3);
        recv_byte(d, 1'b1);
        bus_stop;
        ok = a1 & a2 & a3;
    endtask

    initial begin
        logic a1, a2, a3, a4, ok;
        logic [7:0] d;
        int we0;

        tick(5);
        check("R1 sda_oe in reset", int'(sda_oe), 0);
        check("R1 reg_we in reset", int'(reg_we), 0);
        rst = 1'b0;
        tick(5);
        check("R1 sda_oe after reset", int'(sda_oe), 0);

        // Vector table: single write, then indirect read back
        for (int v = 0; v < NVEC; v++) begin
            we0 = we_cnt;
            set_index(VEC[v][15:8], a1, a2);
            send_byte(VEC[v][7:0], a3);
            bus_stop;
            check("R3 write acks", int'({a1, a2, a3}), 7);
            check("R4 one strobe per byte", we_cnt - we0, 1);
            read_one(VEC[v][15:8], d, ok);
            check("R7 read acks", int'(ok), 1);
            check("R7 read data", int'(d), int'(VEC[v][7:0]));
        end

        // Burst write and burst read with auto-increment
        we0 = we_cnt;
        set_index(8'h08, a1, a2);
        send_byte(8'h11, a3);
        send_byte(8'h22, a4);
        check("R5 burst acks", int'({a1, a2, a3, a4}), 15);
        send_byte(8'h33, a3);
        bus_stop;
        check("R5 burst strobes", we_cnt - we0, 3);
        set_index(8'h08, a1, a2);
        bus_start;
        send_byte(DEV_R, a3);
        recv_byte(d, 1'b0);
        check("R8 burst byte 0", int'(d), 8'h11);
        recv_byte(d, 1'b0);
        check("R5 burst byte 1", int'(d), 8'h22);
        recv_byte(d, 1'b1);
        check("R8 burst byte 2", int'(d), 8'h33);
        tick(Q);
        check("R8 release after master nack", int'(sda_oe), 0);
        we0 = oe_seen;
        send_bits(8'h00, 8);
        tick(Q);
        check("R8 ignored after master nack", oe_seen - we0, 0);
        bus_stop;

        // Undefined register address: nack, index unchanged
        set_index(8'h12, a1, a2);
        send_byte(8'h6E, a3);
        bus_stop;
        set_index(8'h12, a1, a2);
        bus_stop;
        we0 = we_cnt;
        set_index(8'h40, a1, a2);
        check("R6 dev ack before bad reg", int'(a1), 1);
        check("R6 bad reg nack", int'(a2), 0);
        send_byte(8'hEE, a3);
        bus_stop;
        check("R6 data after bad reg nack", int'(a3), 0);
        check("R6 no strobe", we_cnt - we0, 0);
        bus_start;
        send_byte(DEV_R, a3);
        recv_byte(d, 1'b1);
        bus_stop;
        check("R6 index kept", int'(d), 8'h6E);

        // Burst running past the last defined register
        we0 = we_cnt;
        set_index(8'h1F, a1, a2);
        send_byte(8'hC3, a3);
        send_byte(8'h99, a4);
        bus_stop;
        check("R6 last reg ack", int'(a3), 1);
        check("R6 past end nack", int'(a4), 0);
        check("R6 single strobe at boundary", we_cnt - we0, 1);
        bus_start;
        send_byte(DEV_R, a3);
        bus_stop;
        check("R7 read nack at undefined index", int'(a3), 0);
        read_one(8'h1F, d, ok);
        check("R7 boundary data", int'(d), 8'hC3);

        // Wrong device address
        we0 = oe_seen;
        bus_start;
        send_byte(BAD_W, a1);
        send_byte(8'h02, a2);
        bus_stop;
        check("R2 wrong address nack", int'({a1, a2}), 0);
        check("R2 bus released", oe_seen - we0, 0);
        set_index(8'h03, a1, a2);
        bus_start;
        send_byte(BAD_R, a3);
        bus_stop;
        check("R2 different address after Sr", int'(a3), 0);

        // Abort by stop and by start in mid byte
        bus_start;
        send_bits(DEV_W, 4);
        bus_stop;
        bus_start;
        send_bits(DEV_W, 3);
        set_index(8'h02, a1, a2);
        send_byte(8'hE7, a3);
        bus_stop;
        check("R9 after aborts acks", int'({a1, a2, a3}), 7);
        read_one(8'h02, d, ok);
        check("R9 after aborts data", int'(d), 8'hE7);

        tick(4);
        check("R10 sda_oe stable while SCL high", oe_hi_changes, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule